// File: doc/BRIEF.md
# Skip-Counting Microcode Sequencer

This block steps through a 4096-word microprogram held in an external synchronous ROM and supplies one 8-bit microinstruction per clock. Program flow has only three ways to change. A direct jump reaches one of the first sixteen words. An indirect jump reaches one of 256 entry points that sit on 16-word boundaries, with the entry number taken from an opcode latch. A conditional skip moves forward over up to fifteen words. Every other opcode is passed to the datapath on `instr` and simply lets the address advance.

A taken skip never loads the address register. The low nibble of the held instruction becomes a down-counter instead. While it is nonzero and the tested flag is 0, no new word is accepted, and the address keeps counting up. When the counter reaches zero, the word at the skip target is the one waiting on the ROM port. The test vector has four bits: three condition bits from the datapath and an interrupt bit that this block owns. The interrupt bit follows a synchronized `irq_req` only at the first skip of a chain, and only while `irq_en` is high.

The ROM port is a fixed-latency port with no handshake and no back-pressure. The word addressed in one cycle must appear on `rom_data` in the next cycle, and the sequencer never stalls it. The datapath inputs are plain level signals.

Top module: `skip_useq`

## Requirements
- R1: While `rst_n` is low, `instr` is 0x00 and `rom_addr` is 0x000, and the interrupt bit is 1. The first word executed after release is the word at address 0x000.
- R2: On any cycle that neither jumps nor skips, the fetch address is one more than the previous one, modulo 4096, so 0xFFF is followed by 0x000.
- R3: After opcode 0x9n is executed, the next fetch is from address 0x00n.
- R4: After any opcode 0xB0–0xBF is executed, the next fetch is from address {`op_latch`, 4'h0}.
- R5: Opcodes 0xC0–0xFF are skips. Bits 5:4 select a bit of the vector {interrupt bit, `cond_flags[2]`, `cond_flags[1]`, `cond_flags[0]`} (bit 3 down to bit 0), and bits 3:0 hold a distance d. When the selected bit is 0 and d is nonzero, the next d cycles fetch nothing. In those cycles `instr` keeps its upper nibble and its lower nibble counts down to 0, while the address still advances. The next word executed is then the one at skip address + 1 + d.
- R6: A skip whose selected bit is 1, or whose distance is 0, lets the next word execute on the following cycle.
- R7: With `irq_en` high, the interrupt bit is rewritten only on a cycle that fetches a skip opcode while the instruction held before it is not a skip. It becomes 0 if the synchronized request is high and 1 if it is low. At all other times it holds its value.
- R8: While `irq_en` is low, the interrupt bit is forced to 1 at each clock edge and is not rewritten from the request.
- R9: `irq_req` passes through two flip-flops. An update at a fetch edge uses the request level that was captured two edges earlier.
- R10: The word on `rom_data` in a fetch cycle is the one addressed by `rom_addr` in the cycle before, and it appears on `instr` after that fetch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_data | input | 8 | Word from the synchronous microcode ROM, addressed in the previous cycle |
| cond_flags | input | 3 | Datapath condition bits, test vector bits 2:0 |
| op_latch | input | 8 | Entry number used by the indirect jump |
| irq_req | input | 1 | Asynchronous interrupt request |
| irq_en | input | 1 | Interrupt enable; low forces the interrupt bit to 1 |
| rom_addr | output | 12 | Address of the word to be fetched next |
| instr | output | 8 | Microinstruction being executed, or the skip counter while skipping |

## Verification
The properties assume that `cond_flags` and `op_latch` are settled before each rising edge. They also assume that `rom_data` is the registered reply to the previous `rom_addr`, because the next address depends combinationally on that word. `irq_req` may change at any time, but the properties only look at the synchronized copy. The stimulus changes every input at the falling edge and answers from a registered ROM model. The request and enable waveforms are scheduled against the predicted fetch address, so that a late request edge, a masked window and a chained skip each fall on a known fetch.

// File: rtl/skip_useq_pkg.sv
package skip_useq_pkg;

  localparam int IR_W    = 8;   // microinstruction width
  localparam int DIST_W  = 4;   // skip distance / page offset width
  localparam int SEL_W   = 2;   // flag selector width
  localparam int NFLAG   = 4;   // size of the tested flag vector
  localparam int SEL_LO  = DIST_W;
  localparam int SEL_HI  = DIST_W + SEL_W - 1;

  typedef enum logic [1:0] {
    OPK_PLAIN,
    OPK_JDIR,
    OPK_JIND,
    OPK_SKIP
  } opk_e;

  // Flow class of a microinstruction word
  function automatic opk_e classify(input logic [IR_W-1:0] w);
    if (w[7:6] == 2'b11)      return OPK_SKIP;
    else if (w[7:4] == 4'h9)  return OPK_JDIR;
    else if (w[7:4] == 4'hB)  return OPK_JIND;
    return OPK_PLAIN;
  endfunction

endpackage

// File: rtl/skip_useq_irqflag.sv
module skip_useq_irqflag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic irq_en,
  input  logic upd,
  output logic flag
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   irq_sync;
  logic                   flag_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= irq_req;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], irq_req};
      end
    end
  endgenerate

  assign irq_sync = chain_q[SYNC_STAGES-1];

  // Active-low interrupt bit: 0 means a request was seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (!irq_en) flag_q <= 1'b1;
    else if (upd)     flag_q <= ~irq_sync;
  end

  assign flag = flag_q;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> flag_q);  // R8

  AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !upd) |=> $stable(flag_q));  // R7

endmodule

// File: rtl/skip_useq_window.sv
module skip_useq_window
  import skip_useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   rom_data,
  input  logic [NFLAG-2:0]  cond_flags,
  input  logic              irq_flag,
  output logic [IR_W-1:0]   ir,
  output logic              skipping,
  output logic              irq_upd
);

  logic [IR_W-1:0]  ir_q;
  logic [NFLAG-1:0] flag_vec;
  logic             sel_bit;
  logic             held_skip;
  logic             dist_live;

  assign flag_vec  = {irq_flag, cond_flags};
  assign sel_bit   = flag_vec[ir_q[SEL_HI:SEL_LO]];
  assign held_skip = (classify(ir_q) == OPK_SKIP);
  assign dist_live = (ir_q[DIST_W-1:0] != '0);

  // Counting down replaces fetching while the tested bit is clear
  assign skipping = held_skip && dist_live && !sel_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ir_q <= '0;
    else if (skipping)
      ir_q <= {ir_q[IR_W-1:DIST_W], ir_q[DIST_W-1:0] - DIST_W'(1)};
    else
      ir_q <= rom_data;
  end

  // Interrupt sampling only at the head of a skip chain
  assign irq_upd = !skipping && (classify(rom_data) == OPK_SKIP) && !held_skip;
  assign ir      = ir_q;

  AST_SKIP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |=> (ir_q[DIST_W-1:0] == $past(ir_q[DIST_W-1:0]) - DIST_W'(1))
                 && (ir_q[IR_W-1:DIST_W] == $past(ir_q[IR_W-1:DIST_W])));  // R5

  AST_SKIP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (held_skip && sel_bit) |=> (ir_q == $past(rom_data)));  // R6

endmodule

// File: rtl/skip_useq_pc.sv
module skip_useq_pc
  import skip_useq_pkg::*;
#(
  parameter int OP_W = 8,
  localparam int PC_W = OP_W + DIST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             skipping,
  input  logic [IR_W-1:0]  rom_data,
  input  logic [OP_W-1:0]  op_latch,
  output logic [PC_W-1:0]  pc_nxt
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_inc;

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    pc_nxt = pc_inc;
    if (!skipping) begin
      case (classify(rom_data))
        OPK_JDIR: pc_nxt = PC_W'(rom_data[DIST_W-1:0]);
        OPK_JIND: pc_nxt = {op_latch, {DIST_W{1'b0}}};
        default:  pc_nxt = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |=> (pc_q == $past(pc_q) + PC_W'(1)));  // R2

  AST_DIRECT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!skipping && rom_data[7:4] == 4'h9) |=> (pc_q == PC_W'($past(rom_data[DIST_W-1:0]))));  // R3

  AST_INDIRECT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!skipping && rom_data[7:4] == 4'hB) |=> (pc_q == {$past(op_latch), {DIST_W{1'b0}}}));  // R4

endmodule

// File: rtl/skip_useq.sv
module skip_useq
  import skip_useq_pkg::*;
#(
  parameter int OP_W        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PC_W       = OP_W + DIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   rom_data,
  input  logic [NFLAG-2:0]  cond_flags,
  input  logic [OP_W-1:0]   op_latch,
  input  logic              irq_req,
  input  logic              irq_en,
  output logic [PC_W-1:0]   rom_addr,
  output logic [IR_W-1:0]   instr
);

  logic            skipping;
  logic            irq_upd;
  logic            irq_flag;
  logic [PC_W-1:0] pc_nxt;

  skip_useq_irqflag #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_irqflag (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .upd     (irq_upd),
    .flag    (irq_flag)
  );

  skip_useq_window u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .rom_data   (rom_data),
    .cond_flags (cond_flags),
    .irq_flag   (irq_flag),
    .ir         (instr),
    .skipping   (skipping),
    .irq_upd    (irq_upd)
  );

  skip_useq_pc #(
    .OP_W (OP_W)
  ) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .skipping (skipping),
    .rom_data (rom_data),
    .op_latch (op_latch),
    .pc_nxt   (pc_nxt)
  );

  // ROM samples the next address so its word is ready on the following cycle
  assign rom_addr = rst_n ? pc_nxt : '0;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (instr == '0) && (rom_addr == '0));  // R1

endmodule

// File: tb/skip_useq_bench.sv
module skip_useq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rom_data;
  logic [2:0]  cond_flags;
  logic [7:0]  op_latch;
  logic        irq_req;
  logic        irq_en;
  logic [11:0] rom_addr;
  logic [7:0]  instr;

  always #5 clk = ~clk;

  skip_useq u_skip_useq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rom_data   (rom_data),
    .cond_flags (cond_flags),
    .op_latch   (op_latch),
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .rom_addr   (rom_addr),
    .instr      (instr)
  );

  // Microprogram: computed filler plus a few flow words
  function automatic logic [7:0] rom_fn(input logic [11:0] a);
    case (a)
      12'h001: return 8'h95;  // direct jump to 5
      12'h005: return 8'hC3;  // skip 3 on cond bit 0
      12'h009: return 8'hD2;  // skip 2 on cond bit 1 (set)
      12'h00A: return 8'hE0;  // skip 0 on cond bit 2 (clear)
      12'h00B: return 8'hB0;  // indirect jump
      12'h123: return 8'h9C;  // direct jump to 0x00C
      12'h00D: return 8'hF4;  // skip 4 on interrupt bit
      12'h012: return 8'hF2;  // chained skip, no resample
      12'h016: return 8'hF1;
      12'h01A: return 8'hF1;
      12'h01D: return 8'hF1;  // masked
      12'h01F: return 8'hF1;  // late request edge
      12'h021: return 8'hB0;  // indirect jump to top page
      default: return {1'b0, a[6:0]};
    endcase
  endfunction

  always @(posedge clk) rom_data <= rom_fn(rom_addr);

  function automatic logic irq_sched(input logic [11:0] a);
    return (a >= 12'h120 && a <= 12'h12F) || (a >= 12'h00C && a <= 12'h011) ||
           (a >= 12'h018 && a <= 12'h01D);
  endfunction

  function automatic logic en_sched(input logic [11:0] a);
    return !(a == 12'h01C || a == 12'h01D);
  endfunction

  function automatic logic [7:0] op_sched(input logic [11:0] a);
    return (a < 12'h010) ? 8'h12 : 8'hFF;
  endfunction

  typedef struct {
    logic [7:0] ir;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [11:0] got, input logic [11:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Reference state
  logic [11:0] m_pc;
  logic [7:0]  m_ir;
  logic        m_flag;
  logic        m_h1, m_h2;

  task automatic model_reset();
    m_pc = 12'h000; m_ir = 8'h00; m_flag = 1'b1; m_h1 = 1'b0; m_h2 = 1'b0;
  endtask

  // Driver: set inputs for the coming edge, predict, push
  task automatic drive_step(input bit first);
    logic [3:0]  fv;
    logic        irq_d;
    logic [7:0]  w;
    logic        was;
    logic [11:0] a;
    exp_t        e;
    irq_req    = irq_sched(m_pc);
    irq_en     = en_sched(m_pc);
    op_latch   = op_sched(m_pc);
    fv         = {m_flag, cond_flags};
    irq_d      = m_h2;
    m_h2       = m_h1;
    m_h1       = irq_req;
    if (m_ir[7:6] == 2'b11 && m_ir[3:0] != 4'h0 && !fv[m_ir[5:4]]) begin
      m_ir[3:0] = m_ir[3:0] - 4'h1;
      m_pc      = m_pc + 12'h001;
      e.tag     = "R5";
      if (!irq_en) m_flag = 1'b1;
    end else begin
      a   = m_pc;
      w   = rom_fn(a);
      was = (m_ir[7:6] == 2'b11);
      if (first)                          e.tag = "R1";
      else if (w[7:4] == 4'h9)            e.tag = "R3";
      else if (w[7:4] == 4'hB)            e.tag = "R4";
      else if (a == 12'h01D)              e.tag = "R8";
      else if (a == 12'h01F)              e.tag = "R9";
      else if (w[7:4] == 4'hF)            e.tag = "R7";
      else if (w[7:6] == 2'b11)           e.tag = "R6";
      else if (a >= 12'hFF0 || a == 12'h000) e.tag = "R2";
      else                                e.tag = "R10";
      m_ir = w;
      if (w[7:4] == 4'h9)      m_pc = {8'h00, w[3:0]};
      else if (w[7:4] == 4'hB) m_pc = {op_latch, 4'h0};
      else                     m_pc = m_pc + 12'h001;
      if (!irq_en)                        m_flag = 1'b1;
      else if (!was && w[7:6] == 2'b11)   m_flag = ~irq_d;
    end
    e.ir = m_ir;
    exp_q.push_back(e);
  endtask

  // Monitor: compare the executed word just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "instr", {4'h0, instr}, {4'h0, e.ir});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    cond_flags = 3'b010;
    op_latch   = 8'h00;
    irq_req    = 1'b0;
    irq_en     = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", "instr in reset", {4'h0, instr}, 12'h000);
    check("R1", "rom_addr in reset", rom_addr, 12'h000);

    // Two passes through the program with a wrap through the top page
    for (int i = 0; i < 100; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 0) rst_n = 1'b1;
      drive_step(i == 0);
    end
    @(negedge clk);

    // Reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "instr in reset", {4'h0, instr}, 12'h000);
    check("R1", "rom_addr in reset", rom_addr, 12'h000);
    @(negedge clk);
    model_reset();
    for (int i = 0; i < 14; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 0) rst_n = 1'b1;
      drive_step(i == 0);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule